// File: doc/BRIEF.md
# Integer Data-Processing ALU with Carry and Borrow Flags

This block is the arithmetic and move unit of a small RISC execution stage. The block is purely combinational. In the same cycle it receives a 4-bit operation code, a first operand read from a register, and a second operand. The second operand has already been shifted or expanded from an immediate by logic upstream. The block also receives the current carry and overflow flags. It returns the 32-bit result together with candidate negative, zero, carry and overflow flags.

Every subtraction is computed as an addition of the inverted subtrahend. Carry out therefore means "no borrow". The carry-using subtract forms take the inverted carry flag as their borrow-in. Reverse forms swap the operand order, so the register operand becomes the subtrahend.

The block does not decide whether the flags are written. A set-flags request from the instruction decoder passes straight through as a flag write-enable, and the caller latches the flags when that enable is high.

Top module: `dp_alu`

## Requirements
- R1: Code 0 (move) returns the second operand unchanged, whatever the first operand is. Its carry flag equals the shifter carry input, and its overflow flag equals the incoming overflow flag.
- R2: Code 1 (inverted move) returns the bitwise complement of the second operand. Its carry and overflow flags follow the same rule as in R1.
- R3: Code 2 (add) returns first + second modulo 2^32. The carry flag is the unsigned carry out of bit 31.
- R4: Code 3 (add with carry) returns first + second + carry_in. The carry flag is the unsigned carry out.
- R5: Code 4 (subtract) returns first − second. The carry flag is 1 exactly when first ≥ second as unsigned numbers (no borrow).
- R6: Code 5 (subtract with carry) returns first − second − (1 − carry_in). The carry flag is 1 exactly when no borrow occurred.
- R7: Code 6 (reverse subtract) returns second − first. The carry flag is 1 exactly when second ≥ first as unsigned numbers.
- R8: Code 7 (reverse subtract with carry) returns second − first − (1 − carry_in). The carry flag is 1 exactly when no borrow occurred.
- R9: For every code, the negative flag equals result bit 31, and the zero flag is 1 exactly when all 32 result bits are 0.
- R10: For codes 2 to 7, the overflow flag is 1 exactly when the two's-complement result does not fit in 32 signed bits.
- R11: The flag write-enable output equals the set-flags input for every operation code.
- R12: Codes 8 to 15 behave exactly as code 0 (move).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code (see R1 to R8, R12) |
| opa | input | 32 | First operand, from a register |
| opb | input | 32 | Second operand, already shifted or an immediate |
| carry_in | input | 1 | Current carry flag |
| shift_carry | input | 1 | Carry out of the shifter, used by the move forms |
| ovf_in | input | 1 | Current overflow flag, kept by the move forms |
| set_flags | input | 1 | Request to update the flags |
| result | output | 32 | Operation result |
| flag_n | output | 1 | Candidate negative flag |
| flag_z | output | 1 | Candidate zero flag |
| flag_c | output | 1 | Candidate carry flag |
| flag_v | output | 1 | Candidate overflow flag |
| flag_we | output | 1 | Flag write-enable, copied from set_flags |

## Verification
The hardest cases to reach are the carry chain edges of the carry-using subtract forms. A carry-in of 0 must turn an exact-zero difference into a borrow with an all-ones result. Signed overflow must appear at 0x80000000 and 0x7FFFFFFF but not next to them. Random 32-bit operands almost never land on these points. The stimulus therefore crosses a fixed set of edge values (0, 1, 0x7FFFFFFF, 0x80000000, 0xFFFFFFFF) over every code and both carry-in values before it adds random operands. Each stimulus item is compared against a model that uses widened arithmetic with explicit borrow rather than the inverted-operand form.

// File: rtl/dp_alu_pkg.sv
// Package dp_alu_pkg
// Shared operation codes for the data-processing ALU.
// Assumes a 4-bit operation select; codes not listed act as a move.
package dp_alu_pkg;

    typedef enum logic [3:0] {
        OP_MOV = 4'd0,
        OP_MVN = 4'd1,
        OP_ADD = 4'd2,
        OP_ADC = 4'd3,
        OP_SUB = 4'd4,
        OP_SBC = 4'd5,
        OP_RSB = 4'd6,
        OP_RSC = 4'd7
    } dp_op_e;

endpackage

// File: rtl/dp_operand_sel.sv
// Module dp_operand_sel
// Maps the operation code onto the inputs of a single adder. Every
// subtract form is expressed as a + ~b + cin, so one adder serves all
// arithmetic codes. Also reports whether the code is a move form.
// Assumes: combinational, no state; codes 8..15 are treated as a move.
module dp_operand_sel
    import dp_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [3:0]       op_sel,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic             carry_in,
    output logic [WIDTH-1:0] add_a,
    output logic [WIDTH-1:0] add_b,
    output logic             add_cin,
    output logic             is_move,
    output logic             is_inv_move
);

    // Purpose: pick adder operands and carry-in for each operation.
    always_comb begin
        add_a       = opa;
        add_b       = opb;
        add_cin     = 1'b0;
        is_move     = 1'b0;
        is_inv_move = 1'b0;
        case (op_sel)
            OP_ADD: begin
                add_cin = 1'b0;
            end
            OP_ADC: begin
                add_cin = carry_in;
            end
            OP_SUB: begin
                add_b   = ~opb;
                add_cin = 1'b1;
            end
            OP_SBC: begin
                add_b   = ~opb;
                add_cin = carry_in;
            end
            OP_RSB: begin
                add_a   = opb;
                add_b   = ~opa;
                add_cin = 1'b1;
            end
            OP_RSC: begin
                add_a   = opb;
                add_b   = ~opa;
                add_cin = carry_in;
            end
            OP_MVN: begin
                is_move     = 1'b1;
                is_inv_move = 1'b1;
            end
            default: begin
                is_move = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/dp_adder.sv
// Module dp_adder
// WIDTH-bit binary adder with carry-in. Returns the sum, the unsigned
// carry out of the top bit and the two's-complement overflow indication.
// Assumes: combinational; operands are already inverted for subtraction.
module dp_adder #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             ovf
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0] wide_sum;

    // Purpose: one wide addition gives the sum and the carry out together.
    always_comb begin
        wide_sum = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
        sum      = wide_sum[MSB:0];
        cout     = wide_sum[WIDTH];
    end

    // Purpose: overflow when both addends share a sign the sum lacks.
    always_comb begin
        ovf = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
    end

endmodule

// File: rtl/dp_flag_gen.sv
// Module dp_flag_gen
// Forms the candidate N, Z, C and V flags from the selected result.
// Move forms take C from the shifter and keep the incoming V.
// Assumes: combinational; the caller decides whether to latch the flags.
module dp_flag_gen #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] res,
    input  logic             is_move,
    input  logic             shift_carry,
    input  logic             ovf_in,
    input  logic             add_cout,
    input  logic             add_ovf,
    output logic             flag_n,
    output logic             flag_z,
    output logic             flag_c,
    output logic             flag_v
);

    localparam int MSB = WIDTH - 1;

    // Purpose: sign and zero flags come from the result in every mode.
    always_comb begin
        flag_n = res[MSB];
        flag_z = ~|res;
    end

    // Purpose: carry and overflow depend on whether the adder was used.
    always_comb begin
        if (is_move) begin
            flag_c = shift_carry;
            flag_v = ovf_in;
        end else begin
            flag_c = add_cout;
            flag_v = add_ovf;
        end
    end

endmodule

// File: rtl/dp_alu.sv
// Module dp_alu (top)
// Combinational data-processing ALU: moves, inverted moves, add, subtract
// and reverse subtract, each with a carry-using form. Borrow is the
// inverse of carry. The set-flags request passes through as flag_we.
// Assumes: operand 2 is already shifted; no clock and no reset inside.
module dp_alu
    import dp_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [3:0]       op_sel,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic             carry_in,
    input  logic             shift_carry,
    input  logic             ovf_in,
    input  logic             set_flags,
    output logic [WIDTH-1:0] result,
    output logic             flag_n,
    output logic             flag_z,
    output logic             flag_c,
    output logic             flag_v,
    output logic             flag_we
);

    logic [WIDTH-1:0] add_a;
    logic [WIDTH-1:0] add_b;
    logic             add_cin;
    logic             is_move;
    logic             is_inv_move;
    logic [WIDTH-1:0] add_sum;
    logic             add_cout;
    logic             add_ovf;

    dp_operand_sel #(.WIDTH(WIDTH)) u_sel (
        .op_sel      (op_sel),
        .opa         (opa),
        .opb         (opb),
        .carry_in    (carry_in),
        .add_a       (add_a),
        .add_b       (add_b),
        .add_cin     (add_cin),
        .is_move     (is_move),
        .is_inv_move (is_inv_move)
    );

    dp_adder #(.WIDTH(WIDTH)) u_add (
        .a    (add_a),
        .b    (add_b),
        .cin  (add_cin),
        .sum  (add_sum),
        .cout (add_cout),
        .ovf  (add_ovf)
    );

    // Purpose: choose between the move path and the adder sum.
    always_comb begin
        if (is_inv_move)  result = ~opb;
        else if (is_move) result = opb;
        else              result = add_sum;
    end

    dp_flag_gen #(.WIDTH(WIDTH)) u_flags (
        .res         (result),
        .is_move     (is_move),
        .shift_carry (shift_carry),
        .ovf_in      (ovf_in),
        .add_cout    (add_cout),
        .add_ovf     (add_ovf),
        .flag_n      (flag_n),
        .flag_z      (flag_z),
        .flag_c      (flag_c),
        .flag_v      (flag_v)
    );

    // Purpose: flags are only presented; the write decision is the caller's.
    always_comb begin
        flag_we = set_flags;
    end

    // Purpose: guard the port-level relations the requirements promise.
    always_comb begin
        if (op_sel == OP_MOV || op_sel > OP_RSC) begin
            assert_move_pass_R1: assert (result == opb && flag_c == shift_carry)
                else $error("move result or carry wrong");
            assert_move_keeps_v_R12: assert (flag_v == ovf_in)
                else $error("move changed overflow");
        end
        if (op_sel == OP_ADD) begin
            assert_add_carry_R3: assert (flag_c == (opb > ~opa))
                else $error("add carry wrong");
        end
        if (op_sel == OP_SUB) begin
            assert_sub_noborrow_R5: assert (flag_c == (opa >= opb))
                else $error("subtract carry wrong");
        end
        if (op_sel == OP_RSB) begin
            assert_rsb_noborrow_R7: assert (flag_c == (opb >= opa))
                else $error("reverse subtract carry wrong");
        end
        assert_zero_flag_R9: assert (flag_z == (result == '0))
            else $error("zero flag disagrees with result");
    end

endmodule

// File: tb/sim_dp_alu.sv
module sim_dp_alu;

    localparam int W = 32;

    typedef struct {
        logic [3:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic        cin;
        logic        sc;
        logic        vin;
        logic        sf;
        logic [31:0] res;
        logic        n;
        logic        z;
        logic        c;
        logic        v;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic [3:0]  op_sel = '0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        carry_in = 1'b0;
    logic        shift_carry = 1'b0;
    logic        ovf_in = 1'b0;
    logic        set_flags = 1'b0;
    logic [31:0] result;
    logic        flag_n, flag_z, flag_c, flag_v, flag_we;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    exp_t q[$];

    dp_alu #(.WIDTH(W)) u0 (
        .op_sel(op_sel), .opa(opa), .opb(opb), .carry_in(carry_in),
        .shift_carry(shift_carry), .ovf_in(ovf_in), .set_flags(set_flags),
        .result(result), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c),
        .flag_v(flag_v), .flag_we(flag_we)
    );

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2: return "R3";
            4'd3: return "R4";
            4'd4: return "R5";
            4'd5: return "R6";
            4'd6: return "R7";
            4'd7: return "R8";
            default: return "R12";
        endcase
    endfunction

    // Reference model: explicit 33-bit add or subtract with a borrow term.
    function automatic exp_t model(input exp_t e);
        exp_t r = e;
        logic [32:0] w;
        logic [31:0] x, y;
        logic        borrow;
        bit          sub;
        sub = 1'b0; x = e.a; y = e.b; borrow = 1'b0; w = '0;
        case (e.op)
            4'd1: begin r.res = ~e.b; r.c = e.sc; r.v = e.vin; end
            4'd2: w = {1'b0, e.a} + {1'b0, e.b};
            4'd3: w = {1'b0, e.a} + {1'b0, e.b} + {32'd0, e.cin};
            4'd4: begin sub = 1'b1; end
            4'd5: begin sub = 1'b1; borrow = ~e.cin; end
            4'd6: begin sub = 1'b1; x = e.b; y = e.a; end
            4'd7: begin sub = 1'b1; x = e.b; y = e.a; borrow = ~e.cin; end
            default: begin r.res = e.b; r.c = e.sc; r.v = e.vin; end
        endcase
        if (e.op >= 4'd2 && e.op <= 4'd7) begin
            if (sub) begin
                w = {1'b0, x} - {1'b0, y} - {32'd0, borrow};
                r.c = ~w[32];
                r.res = w[31:0];
                r.v = (x[31] != y[31]) && (r.res[31] != x[31]);
            end else begin
                r.c = w[32];
                r.res = w[31:0];
                r.v = (e.a[31] == e.b[31]) && (r.res[31] != e.a[31]);
            end
        end
        r.n = r.res[31];
        r.z = (r.res == 32'd0);
        return r;
    endfunction

    // Driver: apply one item at the falling edge, queue its expectation.
    task automatic drive(input logic [3:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic cin,
                         input logic sc, input logic vin, input logic sf);
        exp_t e;
        @(negedge clk);
        e.op = op; e.a = a; e.b = b; e.cin = cin; e.sc = sc; e.vin = vin;
        e.sf = sf; e.res = '0; e.n = 0; e.z = 0; e.c = 0; e.v = 0;
        op_sel = op; opa = a; opb = b; carry_in = cin;
        shift_carry = sc; ovf_in = vin; set_flags = sf;
        q.push_back(model(e));
    endtask

    // Monitor: at each rising edge compare outputs with the oldest item.
    always @(posedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            tests++;
            if (result !== e.res || flag_c !== e.c) begin
                fails++;
                $display("FAIL %s op=%0d a=%h b=%h cin=%0b: res=%h c=%0b expected res=%h c=%0b",
                         req_of(e.op), e.op, e.a, e.b, e.cin, result, flag_c, e.res, e.c);
            end else if (flag_n !== e.n || flag_z !== e.z) begin
                fails++;
                $display("FAIL R9 op=%0d: n=%0b z=%0b expected n=%0b z=%0b",
                         e.op, flag_n, flag_z, e.n, e.z);
            end else if (flag_v !== e.v) begin
                fails++;
                $display("FAIL %s op=%0d a=%h b=%h: v=%0b expected v=%0b",
                         (e.op >= 4'd2 && e.op <= 4'd7) ? "R10" : req_of(e.op),
                         e.op, e.a, e.b, flag_v, e.v);
            end else if (flag_we !== e.sf) begin
                fails++;
                $display("FAIL R11 op=%0d: we=%0b expected we=%0b", e.op, flag_we, e.sf);
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // Stimulus: initial state, edge crossings, then random operands.
    initial begin
        logic [31:0] edges [5];
        edges[0] = 32'h0000_0000; edges[1] = 32'h0000_0001;
        edges[2] = 32'h7FFF_FFFF; edges[3] = 32'h8000_0000;
        edges[4] = 32'hFFFF_FFFF;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // Initial state: all-zero inputs act as a move of zero (R1, R9).
        drive(4'd0, 32'd0, 32'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        // R1: first operand ignored by a move.
        drive(4'd0, 32'hDEAD_BEEF, 32'h1234_5678, 1'b0, 1'b1, 1'b1, 1'b1);
        drive(4'd0, 32'h0000_0000, 32'h1234_5678, 1'b1, 1'b0, 1'b0, 1'b0);
        // R6: zero difference with borrow-in wraps to all ones.
        drive(4'd5, 32'd7, 32'd7, 1'b0, 1'b0, 1'b0, 1'b1);
        // R8: same for the reverse form.
        drive(4'd7, 32'd9, 32'd9, 1'b0, 1'b0, 1'b0, 1'b1);
        for (int op = 0; op < 16; op++)
            for (int i = 0; i < 5; i++)
                for (int j = 0; j < 5; j++)
                    for (int c = 0; c < 2; c++)
                        drive(4'(op), edges[i], edges[j], 1'(c), 1'(c ^ j),
                              1'(i), 1'(c ^ i));
        for (int k = 0; k < 4000; k++)
            drive(4'($urandom_range(0, 15)), $urandom, $urandom,
                  1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule